// File: doc/BRIEF.md
# Interrupt Cycle Sequencer

This block is the part of a small processor's control unit that notices a pending peripheral interrupt and runs a three-step interrupt cycle. It keeps four single-bit state elements: the interrupt enable, the interrupt-cycle marker, the input-ready flag and the output-ready flag. A peripheral raises a flag with a set pulse. An instruction clears a flag with an acknowledge pulse. Two further instruction pulses turn the interrupt enable on and off.

The host's sequence decoder supplies the one-hot timing steps `step[2:0]`. These are the first three states of the sequence counter, and all three are zero in any later state. At the clock edge where no step is active, the block latches the interrupt-cycle marker if interrupts are enabled and either flag is up.

While the marker is set, each of the three steps produces its own register and memory strobes:
- The first step clears the address register and captures the program counter into the temporary register.
- The second step writes that saved value to memory location 0 and zeroes the program counter.
- The third step advances the program counter to 1, clears the sequence counter, and drops both the enable and the marker.

When the marker is clear, the same steps are passed out as fetch enables instead.

Top module: `intr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `int_en`, `int_cycle`, `in_flag` and `out_flag` are all 0. Every output strobe and every `fetch_step` bit is 0 while `step` is 0.
- R2: `int_cycle` goes to 1 at a clock edge where all of the following hold: `int_cycle` is 0, `step` is 3'b000, `int_en` is 1, and `in_flag` or `out_flag` is 1.
- R3: `int_cycle` stays 0 across a clock edge where it is 0 and either `int_en` is 0 or any bit of `step` is 1.
- R4: `addr_clr` and `tmp_from_pc` are 1 exactly when `int_cycle` is 1 and `step[0]` is 1.
- R5: `mem_wr_tmp` and `pc_clr` are 1 exactly when `int_cycle` is 1 and `step[1]` is 1.
- R6: `pc_inc` and `step_clr` are 1 exactly when `int_cycle` is 1 and `step[2]` is 1. At that clock edge, `int_en` and `int_cycle` both become 0, whatever `en_set_req` does.
- R7: `en_set_req` sets `int_en` at the next edge. `en_clr_req` clears it at the next edge. If both are high in the same cycle, the clear wins.
- R8: `in_set` sets `in_flag` and `in_ack` clears it; `out_set` sets `out_flag` and `out_ack` clears it. For each flag, if its set and its clear come together, the clear wins.
- R9: `fetch_step` equals `step` when `int_cycle` is 0, and is 3'b000 when `int_cycle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 3 | One-hot timing steps 0..2 from the sequence decoder, all zero in later states |
| in_set | input | 1 | Peripheral pulse: input data ready |
| out_set | input | 1 | Peripheral pulse: output device ready |
| en_set_req | input | 1 | Instruction pulse: enable interrupts |
| en_clr_req | input | 1 | Instruction pulse: disable interrupts |
| in_ack | input | 1 | Instruction pulse: input taken, clear input flag |
| out_ack | input | 1 | Instruction pulse: output sent, clear output flag |
| int_en | output | 1 | Interrupt enable state |
| int_cycle | output | 1 | Interrupt cycle in progress |
| in_flag | output | 1 | Input-ready flag |
| out_flag | output | 1 | Output-ready flag |
| addr_clr | output | 1 | Clear the address register |
| tmp_from_pc | output | 1 | Load the temporary register from the program counter |
| mem_wr_tmp | output | 1 | Write the temporary register to memory at the address register |
| pc_clr | output | 1 | Clear the program counter |
| pc_inc | output | 1 | Increment the program counter |
| step_clr | output | 1 | Clear the sequence counter |
| fetch_step | output | 3 | Fetch-phase step enables, gated by an idle interrupt cycle |

## Verification
On every cycle, the assertions check the entry and exit rules of the interrupt cycle:
- the cycle never starts while the enable is off or during steps 0 to 2;
- it always starts when its condition holds;
- it leaves the enable off when it ends;
- the clear-over-set priority holds on the enable and on both flags.

The bench runs a cycle-accurate reference model against random steps and pulses. That model is what shows the exact value of each strobe in each step and the fetch gating. Directed scenarios add what a single property cannot show: a whole interrupt cycle running from its trigger to the point where the enable is back off, with the three strobe pairs appearing in order.

// File: rtl/intr_seq.sv
module intr_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] step,
  input  logic       in_set,
  input  logic       out_set,
  input  logic       en_set_req,
  input  logic       en_clr_req,
  input  logic       in_ack,
  input  logic       out_ack,
  output logic       int_en,
  output logic       int_cycle,
  output logic       in_flag,
  output logic       out_flag,
  output logic       addr_clr,
  output logic       tmp_from_pc,
  output logic       mem_wr_tmp,
  output logic       pc_clr,
  output logic       pc_inc,
  output logic       step_clr,
  output logic [2:0] fetch_step
);

  logic idle_step, pending, enter, leave;

  assign idle_step = ~|step;
  assign pending   = in_flag | out_flag;
  assign enter     = ~int_cycle & idle_step & int_en & pending;
  assign leave     = int_cycle & step[2];

  assign addr_clr    = int_cycle & step[0];
  assign tmp_from_pc = int_cycle & step[0];
  assign mem_wr_tmp  = int_cycle & step[1];
  assign pc_clr      = int_cycle & step[1];
  assign pc_inc      = leave;
  assign step_clr    = leave;
  assign fetch_step  = int_cycle ? 3'b000 : step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_cycle <= 1'b0;
      int_en    <= 1'b0;
      in_flag   <= 1'b0;
      out_flag  <= 1'b0;
    end else begin
      if (leave)      int_cycle <= 1'b0;
      else if (enter) int_cycle <= 1'b1;

      if (leave || en_clr_req) int_en <= 1'b0;
      else if (en_set_req)     int_en <= 1'b1;

      if (in_ack)      in_flag <= 1'b0;
      else if (in_set) in_flag <= 1'b1;

      if (out_ack)      out_flag <= 1'b0;
      else if (out_set) out_flag <= 1'b1;
    end
  end

  AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_cycle && !int_en) |=> !int_cycle); // R3
  AST_NO_ENTRY_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_cycle && step != 3'b000) |=> !int_cycle); // R3
  AST_ENTRY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_cycle && step == 3'b000 && int_en && (in_flag || out_flag)) |=> int_cycle); // R2
  AST_EXIT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (int_cycle && step[2]) |=> (!int_cycle && !int_en)); // R6
  AST_EN_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_req |=> !int_en); // R7
  AST_IN_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> !in_flag); // R8
  AST_OUT_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    out_ack |=> !out_flag); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step) |-> $onehot0({addr_clr, mem_wr_tmp, pc_inc, |fetch_step})); // R9

endmodule

// File: tb/intr_seq_test.sv
module intr_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] step = 3'b000;
  logic in_set = 0, out_set = 0, en_set_req = 0, en_clr_req = 0, in_ack = 0, out_ack = 0;
  logic int_en, int_cycle, in_flag, out_flag;
  logic addr_clr, tmp_from_pc, mem_wr_tmp, pc_clr, pc_inc, step_clr;
  logic [2:0] fetch_step;

  int checks = 0;
  int failures = 0;
  logic m_en = 0, m_cyc = 0, m_fi = 0, m_fo = 0;

  always #5 clk = ~clk;

  intr_seq uut (
    .clk(clk), .rst_n(rst_n), .step(step), .in_set(in_set), .out_set(out_set),
    .en_set_req(en_set_req), .en_clr_req(en_clr_req), .in_ack(in_ack), .out_ack(out_ack),
    .int_en(int_en), .int_cycle(int_cycle), .in_flag(in_flag), .out_flag(out_flag),
    .addr_clr(addr_clr), .tmp_from_pc(tmp_from_pc), .mem_wr_tmp(mem_wr_tmp),
    .pc_clr(pc_clr), .pc_inc(pc_inc), .step_clr(step_clr), .fetch_step(fetch_step)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic next_cyc(logic c, logic e, logic fi, logic fo, logic [2:0] s);
    if (c && s[2]) return 1'b0;
    if (!c && s == 3'b000 && e && (fi || fo)) return 1'b1;
    return c;
  endfunction

  function automatic logic next_en(logic c, logic e, logic [2:0] s, logic setr, logic clr);
    if ((c && s[2]) || clr) return 1'b0;
    if (setr) return 1'b1;
    return e;
  endfunction

  function automatic logic next_flag(logic f, logic setr, logic clr);
    return clr ? 1'b0 : (setr ? 1'b1 : f);
  endfunction

  task automatic compare_all();
    check("R1/R2/R3/R7/R8 state", {4'b0, int_en, int_cycle, in_flag, out_flag},
          {4'b0, m_en, m_cyc, m_fi, m_fo});
    check("R4 step0 strobes", {6'b0, addr_clr, tmp_from_pc}, {6'b0, {2{m_cyc & step[0]}}});
    check("R5 step1 strobes", {6'b0, mem_wr_tmp, pc_clr}, {6'b0, {2{m_cyc & step[1]}}});
    check("R6 step2 strobes", {6'b0, pc_inc, step_clr}, {6'b0, {2{m_cyc & step[2]}}});
    check("R9 fetch gating", {5'b0, fetch_step}, {5'b0, m_cyc ? 3'b000 : step});
  endtask

  task automatic cycle(input logic [2:0] s, input logic is, os, es, ec, ia, oa);
    logic nc, ne, nfi, nfo;
    step = s; in_set = is; out_set = os; en_set_req = es; en_clr_req = ec;
    in_ack = ia; out_ack = oa;
    #1;
    compare_all();
    nc  = next_cyc(m_cyc, m_en, m_fi, m_fo, s);
    ne  = next_en(m_cyc, m_en, s, es, ec);
    nfi = next_flag(m_fi, is, ia);
    nfo = next_flag(m_fo, os, oa);
    @(posedge clk);
    m_cyc = nc; m_en = ne; m_fi = nfi; m_fo = nfo;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2:0] s;
    int r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset state", {4'b0, int_en, int_cycle, in_flag, out_flag}, 8'h00);
    check("R1 reset strobes", {2'b0, addr_clr, tmp_from_pc, mem_wr_tmp, pc_clr, pc_inc, step_clr}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {4'b0, int_en, int_cycle, in_flag, out_flag}, 8'h00);

    // R3: flag up but interrupts disabled, idle step: no cycle
    cycle(3'b000, 1, 0, 0, 0, 0, 0);
    cycle(3'b000, 0, 0, 0, 0, 0, 0);
    check("R3 no entry when disabled", {7'b0, int_cycle}, 8'h00);
    // R7 set and clear together: clear wins
    cycle(3'b000, 0, 0, 1, 1, 0, 0);
    check("R7 clear beats set", {7'b0, int_en}, 8'h00);
    cycle(3'b001, 0, 0, 1, 0, 0, 0);
    check("R7 set enable", {7'b0, int_en}, 8'h01);
    // R3: during steps no entry
    cycle(3'b010, 0, 0, 0, 0, 0, 0);
    check("R3 no entry in step", {7'b0, int_cycle}, 8'h00);
    // R2 entry then R4..R6 full cycle
    cycle(3'b000, 0, 0, 0, 0, 0, 0);
    check("R2 entry", {7'b0, int_cycle}, 8'h01);
    cycle(3'b001, 0, 0, 0, 0, 0, 0);
    cycle(3'b010, 0, 0, 0, 0, 0, 0);
    cycle(3'b100, 0, 0, 1, 0, 0, 0);
    check("R6 exit clears enable and cycle", {6'b0, int_en, int_cycle}, 8'h00);
    // R8 clear wins on both flags
    cycle(3'b000, 1, 1, 0, 0, 1, 1);
    check("R8 clear beats set", {6'b0, in_flag, out_flag}, 8'h00);
    cycle(3'b000, 0, 1, 0, 0, 0, 0);
    check("R8 out flag set", {7'b0, out_flag}, 8'h01);

    for (int i = 0; i < 4000; i++) begin
      r = $urandom_range(0, 9);
      s = (r < 4) ? 3'b000 : (r < 6) ? 3'b001 : (r < 8) ? 3'b010 : 3'b100;
      cycle(s, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
            $urandom_range(0, 3) == 0, $urandom_range(0, 9) == 0,
            $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule